// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block follows the two phase signals of an incremental shaft encoder and keeps a 16-bit position count. The count goes up or down by one on every legal edge of either phase. The phase inputs and the index (zero-pulse) input are asynchronous. Each passes through a two-stage synchronizer before a small decoder compares the current phase pair with the pair from the cycle before. From that comparison the decoder issues one of three events: a forward step, a backward step, or an illegal jump.

A small register port sets up the block and reads it back. Software picks the direction sense and the limit mode. In index mode, a rising edge of the zero pulse clears the count, and the count otherwise rolls over at 16 bits. In limit mode the zero pulse is ignored, and the count rolls over between zero and a programmable maximum. A status word reports which way the last step went and whether an illegal jump has been seen.

Top module: `qenc_counter`

## Requirements
- R1: Each legal phase transition changes the position count by exactly one. A transition is legal when exactly one of A and B changes between two synchronized samples. No transition leaves the count unchanged.
- R2: With control bit 0 cleared, the phase sequence {A,B} = 00, 10, 11, 01, 00 (A leading) increments the count, and the reverse sequence decrements it. With control bit 0 set, both senses are swapped.
- R3: Status bit 0 reads 1 when the most recent counted step incremented the count and 0 when it decremented it. It reads 0 after reset.
- R4: A transition in which A and B change together leaves the count unchanged and sets status bit 1. Status bit 1 stays set until a write to the status address with data bit 1 set.
- R5: With control bit 1 set (index mode), a rising edge of the synchronized zero pulse clears the count to 0. This clear takes precedence over a step in the same cycle. In this mode the count wraps modulo 65536 in both directions.
- R6: With control bit 1 cleared (limit mode), the zero pulse has no effect. An increment from a count at or above the maximum register gives 0, and a decrement from 0 loads the maximum register.
- R7: A, B and the zero pulse each pass through two flip-flops. An input change set up before rising clock edge k shows in the count after edge k+2 and not before. A state held for a single clock cycle is still counted.
- R8: The register map is: address 0 control (bits 1:0, upper bits read 0), address 1 maximum (reset 0xFFFF), address 2 position (read only, writes ignored), and address 3 status (bits 1:0). After reset, control, position and status read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_z | input | 1 | Encoder zero pulse, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from bus_addr |

## Verification
The assertions assume three things. First, the decoder raises at most one of its step and illegal events in a cycle. Second, the count moves only on such an event or on an index clear. Third, the limit mode applies only while the index mode is off. They also assume that each phase state lasts at least one clock, so that no synchronized sample is skipped.

The stimulus holds every driven state for one to three clocks. It changes the control and maximum registers only after the pipeline has settled. With these rules, the bench model can apply each change at the moment it is driven and compare its result after a fixed settle time.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int QENC_CNT_W = 16;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_MAX  = 2'd1,
    ADDR_POS  = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;

  // Phase pair {A,B} that follows the given pair when A leads B.
  function automatic logic [1:0] fwd_state(input logic [1:0] ab);
    case (ab)
      2'b00:   return 2'b10;
      2'b10:   return 2'b11;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_s,
  input  logic b_s,
  input  logic z_s,
  input  logic invert,
  output logic inc,
  output logic dec,
  output logic ill,
  output logic z_rise
);

  logic [1:0] prev_ab;
  logic [1:0] cur_ab;
  logic       prev_z;
  logic       fwd;
  logic       bwd;

  assign cur_ab = {a_s, b_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ab <= 2'b00;
      prev_z  <= 1'b0;
    end else begin
      prev_ab <= cur_ab;
      prev_z  <= z_s;
    end
  end

  assign fwd    = (cur_ab == fwd_state(prev_ab));
  assign bwd    = (prev_ab == fwd_state(cur_ab));
  assign ill    = ((cur_ab ^ prev_ab) == 2'b11);
  assign inc    = invert ? bwd : fwd;
  assign dec    = invert ? fwd : bwd;
  assign z_rise = z_s & ~prev_z;

  // R1/R4: at most one decode event per cycle
  assert_one_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc, dec, ill}));

  // R4: a double change never produces a step
  assert_ill_no_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ill |-> (!inc && !dec));

endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  input  logic             use_max,
  input  logic [CNT_W-1:0] max_val,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] c,
    input logic             up,
    input logic             lim,
    input logic [CNT_W-1:0] top
  );
    if (up) return (lim && c >= top) ? '0 : c + CNT_W'(1);
    else    return (lim && c == '0)  ? top : c - CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (inc)   cnt_q <= step_count(cnt_q, 1'b1, use_max, max_val);
    else if (dec)   cnt_q <= step_count(cnt_q, 1'b0, use_max, max_val);
  end

  assign cnt = cnt_q;

  assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !(use_max && cnt_q >= max_val)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_wrap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && use_max && cnt_q == '0) |=> cnt_q == $past(max_val));

  assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && use_max && cnt_q >= max_val) |=> cnt_q == '0);

  assert_index_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc || dec || clr) |=> $stable(cnt_q));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W     = QENC_CNT_W,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata
);

  logic [2:0]       sync_q;
  logic             step_inc, step_dec, step_ill, z_rise;
  logic             cfg_invert, cfg_index;
  logic [CNT_W-1:0] max_q;
  logic [CNT_W-1:0] pos;
  logic             dir_up_q, ill_q;
  logic             idx_clr;
  logic             unused_wdata;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(bus_addr);

  qenc_sync #(.WIDTH(3), .STAGES(SYNC_STGS)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({enc_a, enc_b, enc_z}), .q(sync_q)
  );

  qenc_decode decode_i (
    .clk(clk), .rst_n(rst_n),
    .a_s(sync_q[2]), .b_s(sync_q[1]), .z_s(sync_q[0]),
    .invert(cfg_invert),
    .inc(step_inc), .dec(step_dec), .ill(step_ill), .z_rise(z_rise)
  );

  assign idx_clr = z_rise & cfg_index;

  qenc_poscnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .inc(step_inc), .dec(step_dec), .clr(idx_clr),
    .use_max(~cfg_index), .max_val(max_q), .cnt(pos)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_invert <= 1'b0;
      cfg_index  <= 1'b0;
      max_q      <= '1;
      dir_up_q   <= 1'b0;
      ill_q      <= 1'b0;
    end else begin
      if (bus_wr && addr == ADDR_CTRL) begin
        cfg_invert <= bus_wdata[0];
        cfg_index  <= bus_wdata[1];
      end
      if (bus_wr && addr == ADDR_MAX) max_q <= bus_wdata;
      if (step_inc)      dir_up_q <= 1'b1;
      else if (step_dec) dir_up_q <= 1'b0;
      if (step_ill)                                       ill_q <= 1'b1;
      else if (bus_wr && addr == ADDR_STAT && bus_wdata[1]) ill_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: bus_rdata = {{(CNT_W-2){1'b0}}, cfg_index, cfg_invert};
      ADDR_MAX:  bus_rdata = max_q;
      ADDR_POS:  bus_rdata = pos;
      default:   bus_rdata = {{(CNT_W-2){1'b0}}, ill_q, dir_up_q};
    endcase
  end

  assign unused_wdata = ^bus_wdata[CNT_W-1:2];

  assert_dir_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_inc |=> dir_up_q);

  assert_dir_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_dec |=> !dir_up_q);

  assert_ill_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_ill |=> ill_q);

  assert_limit_no_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_index |-> !idx_clr);

endmodule

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int total = 0;
  int bad   = 0;

  logic [1:0]  m_ab = 2'b00;
  logic        m_z = 1'b0;
  logic [15:0] m_cnt = '0;
  logic        m_dir = 1'b0;
  logic        m_ill = 1'b0;
  logic        m_inv = 1'b0;
  logic        m_idx = 1'b0;
  logic [15:0] m_max = 16'hFFFF;

  always #5 clk = ~clk;

  qenc_counter dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic int ab2pos(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] pos2ab(input int p);
    case (p % 4)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [15:0] model_next(input logic [15:0] c, input logic up);
    if (up) begin
      if (!m_idx && c >= m_max) return 16'h0000;
      return c + 16'd1;
    end
    if (!m_idx && c == 16'h0000) return m_max;
    return c - 16'd1;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] ab, input logic z, input int hold);
    int  d;
    logic zr;
    d  = (ab2pos(ab) - ab2pos(m_ab) + 4) % 4;
    zr = z & ~m_z;
    enc_a = ab[1];
    enc_b = ab[0];
    enc_z = z;
    if (d == 2) m_ill = 1'b1;
    if (d == 1 || d == 3) begin
      m_dir = (d == 1) ^ m_inv;
      m_cnt = (zr && m_idx) ? 16'h0000 : model_next(m_cnt, m_dir);
    end else if (zr && m_idx) begin
      m_cnt = 16'h0000;
    end
    m_ab = ab;
    m_z  = z;
    repeat (hold) @(negedge clk);
  endtask

  task automatic step(input logic phys_fwd, input int n);
    for (int i = 0; i < n; i++)
      drive(pos2ab(ab2pos(m_ab) + (phys_fwd ? 1 : 3)), m_z, 1);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    rd(2'd2, v); chk({req, " pos"}, v, m_cnt);
    rd(2'd3, v); chk({req, " stat"}, v, {14'd0, m_ill, m_dir});
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state, R3 direction reset
    rd(2'd0, v); chk("R8 ctrl reset", v, 16'h0000);
    rd(2'd1, v); chk("R8 max reset", v, 16'hFFFF);
    check_all("R8/R3 reset");

    // R1 R2 forward counting, R3 direction
    step(1'b1, 6); settle(); check_all("R1 R2 fwd");

    // R6 backward through zero with default max
    step(1'b0, 8); settle(); check_all("R6 R2 back");

    // R6 limit wrap up
    wr(2'd1, 16'd9); m_max = 16'd9;
    step(1'b1, 12); settle(); check_all("R6 wrap up");
    step(1'b0, 3); settle();
    step(1'b0, 1); settle(); check_all("R6 wrap down");

    // R6 zero pulse ignored in limit mode
    drive(m_ab, 1'b1, 2); drive(m_ab, 1'b0, 2); settle(); check_all("R6 z ignored");

    // R2 inverted sense
    wr(2'd0, 16'h0001); m_inv = 1'b1;
    step(1'b1, 5); settle(); check_all("R2 invert");

    // R4 illegal jump and clear
    drive(pos2ab(ab2pos(m_ab) + 2), 1'b0, 1); settle(); check_all("R4 illegal");
    wr(2'd3, 16'h0002); m_ill = 1'b0; check_all("R4 clear");

    // R8 position write ignored
    wr(2'd2, 16'h1234); check_all("R8 pos readonly");

    // R5 index mode
    wr(2'd0, 16'h0002); m_inv = 1'b0; m_idx = 1'b1;
    step(1'b1, 3); settle();
    drive(m_ab, 1'b1, 2); drive(m_ab, 1'b0, 1); settle(); check_all("R5 clear");
    step(1'b0, 2); settle(); check_all("R5 wrap 16b");
    drive(pos2ab(ab2pos(m_ab) + 1), 1'b1, 1); drive(m_ab, 1'b0, 1); settle();
    check_all("R5 precedence");

    // R7 latency: visible after third edge only
    drive(pos2ab(ab2pos(m_ab) + 1), 1'b0, 0);
    @(negedge clk); @(negedge clk);
    rd(2'd2, v); chk("R7 not yet", v, m_cnt - 16'd1);
    @(negedge clk);
    rd(2'd2, v); chk("R7 arrived", v, m_cnt);

    // Random mix across modes
    for (int blk = 0; blk < 8; blk++) begin
      logic [15:0] c;
      c = 16'($urandom % 4);
      wr(2'd0, c); m_inv = c[0]; m_idx = c[1];
      c = 16'($urandom % 40);
      wr(2'd1, c); m_max = c;
      for (int i = 0; i < 80; i++) begin
        int r;
        int h;
        r = $urandom % 16;
        h = 1 + ($urandom % 3);
        if (r == 0)      drive(pos2ab(ab2pos(m_ab) + 2), m_z, h);
        else if (r == 1) drive(m_ab, ~m_z, h);
        else if (r == 2) drive(m_ab, m_z, h);
        else             drive(pos2ab(ab2pos(m_ab) + ((r & 1) ? 1 : 3)), m_z, h);
        if (i % 20 == 19) begin
          settle();
          check_all("R1 R5 R6 random");
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule